// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital serial side of a telephony PCM codec. Each frame it moves one 8-bit sample out on the transmit line and one in from the receive line. The two directions are framed independently, each by its own frame-sync / slot-enable input. Everything runs on the master clock `clk_i`. In variable-rate mode the per-direction data clocks are oversampled and edge-detected in that domain.

In fixed-rate mode every master-clock cycle of a slot is one bit step. The length of the frame-sync pulse tells the two frame kinds apart: one clock marks a normal frame, two clocks mark a signaling frame. In variable-rate mode the frame-sync input becomes a slot enable and must stay high for the whole slot. Transmit bits advance on rising edges of `tx_dclk_i`, and receive bits are taken on falling edges of `rx_dclk_i`. Bits travel MSB first.

The transmit line is qualified by an output enable. In fixed-rate mode a strobe, intended for an external tri-state buffer, follows that enable. A channel whose sync input stays low for the standby timeout raises a standby flag, and the next sync clears it. A low power-enable input holds the whole port idle. The companding law select is only passed through.

Top module: `pcm_slot_if`

## Requirements
- R1: Fixed mode, transmit: the first clock edge that samples `tx_fs_i` high after it was low starts a slot and captures `tx_byte_i`. `tx_pcm_oe_o` is then high for exactly 8 cycles, and `tx_pcm_o` presents bit 7 down to bit 0, one per cycle.
- R2: Fixed mode, receive: after the start edge on `rx_fs_i`, `rx_pcm_i` is sampled on the next 8 edges, MSB first. One cycle after the 8th sample, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`.
- R3: Fixed mode: if the sync input is still high on the edge after the start edge, the frame is signaling. For that channel, `tx_sig_o` is 1 from the second slot cycle until the next start, and `rx_sig_o` is 1 alongside the received byte. Otherwise the flag is 0.
- R4: `tx_slot_strobe_o` equals `tx_pcm_oe_o` in fixed mode and stays 0 in variable mode.
- R5: Variable mode, transmit: bit 7 is driven from the cycle after the start edge. Each rising edge of `tx_dclk_i` detected while `tx_fs_i` is high advances one bit. The 8th such edge ends the slot.
- R6: Variable mode, receive: `rx_pcm_i` is sampled on each falling edge of `rx_dclk_i` detected while `rx_fs_i` is high. After the 8th sample the byte is presented with a one-cycle valid pulse, and `rx_sig_o` is 0.
- R7: Variable mode: if the slot enable drops before the 8th data-clock edge, the slot is abandoned. The output enable is low after the next edge and no valid pulse is produced. The transmit signaling flag stays 0.
- R8: When a channel's sync input has been sampled low on STANDBY_CYCLES consecutive edges, that channel's standby flag is 1. Here STANDBY_CYCLES = CLK_HZ/1000*STANDBY_MS. The first edge that samples the sync input high clears the flag.
- R9: While `pwr_en_i` is low, both channels are held idle. The output enable, strobe and valid are 0 after the next edge, the standby flags are 0, and a slot in progress is dropped without a valid pulse.
- R10: Transmit and receive framing are independent. A frame on one channel's sync input neither starts nor disturbs the other channel.
- R11: `law_alaw_o` mirrors `alaw_sel_i` (1 = A-law, 0 = μ-law).
- R12: After reset, all outputs are 0. `tx_pcm_o` is 0 whenever `tx_pcm_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; fixed-mode data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | 1 = active, 0 = power-down |
| var_mode_i | input | 1 | 0 = fixed-rate, 1 = variable-rate |
| alaw_sel_i | input | 1 | Companding law select |
| law_alaw_o | output | 1 | Law flag passed to the coder |
| tx_fs_i | input | 1 | Transmit frame sync / slot enable |
| tx_dclk_i | input | 1 | Transmit data clock (variable mode) |
| tx_byte_i | input | 8 | Sample to send, captured at slot start |
| tx_pcm_o | output | 1 | Serial transmit data |
| tx_pcm_oe_o | output | 1 | Transmit drive enable |
| tx_slot_strobe_o | output | 1 | Buffer strobe, fixed mode |
| tx_sig_o | output | 1 | Transmit frame is signaling |
| tx_standby_o | output | 1 | Transmit channel in standby |
| rx_fs_i | input | 1 | Receive frame sync / slot enable |
| rx_dclk_i | input | 1 | Receive data clock (variable mode) |
| rx_pcm_i | input | 1 | Serial receive data |
| rx_byte_o | output | 8 | Received sample |
| rx_valid_o | output | 1 | One-cycle pulse: rx_byte_o is new |
| rx_sig_o | output | 1 | Received frame is signaling |
| rx_standby_o | output | 1 | Receive channel in standby |

## Verification
In fixed mode the enable and first transmit bit appear one cycle after the start edge, and the received byte appears one cycle after the 8th sample edge, nine cycles after the start edge. In variable mode a transmit bit changes one cycle after a data-clock level change is sampled, and the receive result follows the 8th sampled falling edge by one cycle. Standby rises exactly STANDBY_CYCLES edges after the last high sync sample. Inputs change and outputs are read on the falling master-clock edge, so every check lands in the half cycle after the edge that should have produced the result. Received bytes are queued when their frame is driven and compared whenever a valid pulse appears, so a missing, extra or late result is caught.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
  localparam int unsigned SLOT_BITS_DEF = 8;
endpackage

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
  import pcm_slot_pkg::*;
#(
  parameter edge_sel_e   EDGE           = EDGE_RISE,
  parameter int unsigned SLOT_BITS      = SLOT_BITS_DEF,
  parameter int unsigned STANDBY_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic var_mode_i,
  input  logic fs_i,
  input  logic dclk_i,
  output logic start_o,
  output logic step_o,
  output logic last_o,
  output logic active_o,
  output logic sig_o,
  output logic standby_o
);
  localparam int CW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(STANDBY_CYCLES + 1);

  logic          fs_q, dclk_q, dclk_edge, abort;
  logic          active_q, sig_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] idle_q;

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      assign dclk_edge = dclk_i & ~dclk_q;
    end else begin : g_fall
      assign dclk_edge = ~dclk_i & dclk_q;
    end
  endgenerate

  assign start_o   = en_i & ~active_q & fs_i & ~fs_q;
  assign step_o    = en_i & active_q & (var_mode_i ? (fs_i & dclk_edge) : 1'b1);
  assign last_o    = step_o & (cnt_q == CW'(SLOT_BITS - 1));
  assign abort     = active_q & var_mode_i & ~fs_i;
  assign active_o  = active_q;
  assign sig_o     = sig_q;
  assign standby_o = (idle_q == SW'(STANDBY_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q     <= 1'b0;
      dclk_q   <= 1'b0;
      active_q <= 1'b0;
      sig_q    <= 1'b0;
      cnt_q    <= '0;
      idle_q   <= '0;
    end else begin
      fs_q   <= fs_i;
      dclk_q <= dclk_i;
      if (!en_i) begin
        active_q <= 1'b0;
        sig_q    <= 1'b0;
        cnt_q    <= '0;
        idle_q   <= '0;
      end else begin
        if (start_o) begin
          active_q <= 1'b1;
          sig_q    <= 1'b0;
          cnt_q    <= '0;
        end else if (abort) begin
          active_q <= 1'b0;
        end else if (step_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) active_q <= 1'b0;
          // pulse-length code: sync still high on first bit edge => signaling
          if (cnt_q == '0 && !var_mode_i) sig_q <= fs_i;
        end
        if (fs_i) idle_q <= '0;
        else if (idle_q != SW'(STANDBY_CYCLES)) idle_q <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         last_i,
  input  logic         active_i,
  input  logic [W-1:0] byte_i,
  output logic         pcm_o,
  output logic         oe_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (start_i)            sr_q <= byte_i;
    else if (step_i && !last_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign oe_o  = active_i;
  assign pcm_o = active_i & sr_q[W-1];
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         last_i,
  input  logic         sig_i,
  input  logic         pcm_i,
  output logic [W-1:0] byte_o,
  output logic         valid_o,
  output logic         sig_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      sig_o   <= 1'b0;
    end else begin
      valid_o <= last_i;
      if (step_i) sr_q <= {sr_q[W-2:0], pcm_i};
      if (last_i) begin
        byte_o <= {sr_q[W-2:0], pcm_i};
        sig_o  <= sig_i;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if
  import pcm_slot_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = SLOT_BITS_DEF,
  parameter int unsigned CLK_HZ     = 2_048_000,
  parameter int unsigned STANDBY_MS = 300
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_en_i,
  input  logic                 var_mode_i,
  input  logic                 alaw_sel_i,
  output logic                 law_alaw_o,
  input  logic                 tx_fs_i,
  input  logic                 tx_dclk_i,
  input  logic [SLOT_BITS-1:0] tx_byte_i,
  output logic                 tx_pcm_o,
  output logic                 tx_pcm_oe_o,
  output logic                 tx_slot_strobe_o,
  output logic                 tx_sig_o,
  output logic                 tx_standby_o,
  input  logic                 rx_fs_i,
  input  logic                 rx_dclk_i,
  input  logic                 rx_pcm_i,
  output logic [SLOT_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o,
  output logic                 rx_sig_o,
  output logic                 rx_standby_o
);
  localparam int unsigned STANDBY_CYCLES = CLK_HZ / 1000 * STANDBY_MS;

  logic tx_start, tx_step, tx_last, tx_active;
  logic rx_start, rx_step, rx_last, rx_active, rx_sig_live;
  logic tx_oe;

  pcm_slot_seq #(
    .EDGE(EDGE_RISE), .SLOT_BITS(SLOT_BITS), .STANDBY_CYCLES(STANDBY_CYCLES)
  ) u_tx_seq (
    .clk_i, .rst_ni, .en_i(pwr_en_i), .var_mode_i,
    .fs_i(tx_fs_i), .dclk_i(tx_dclk_i),
    .start_o(tx_start), .step_o(tx_step), .last_o(tx_last),
    .active_o(tx_active), .sig_o(tx_sig_o), .standby_o(tx_standby_o)
  );

  pcm_slot_seq #(
    .EDGE(EDGE_FALL), .SLOT_BITS(SLOT_BITS), .STANDBY_CYCLES(STANDBY_CYCLES)
  ) u_rx_seq (
    .clk_i, .rst_ni, .en_i(pwr_en_i), .var_mode_i,
    .fs_i(rx_fs_i), .dclk_i(rx_dclk_i),
    .start_o(rx_start), .step_o(rx_step), .last_o(rx_last),
    .active_o(rx_active), .sig_o(rx_sig_live), .standby_o(rx_standby_o)
  );

  pcm_tx_shift #(.W(SLOT_BITS)) u_tx_shift (
    .clk_i, .rst_ni, .start_i(tx_start), .step_i(tx_step), .last_i(tx_last),
    .active_i(tx_active), .byte_i(tx_byte_i), .pcm_o(tx_pcm_o), .oe_o(tx_oe)
  );

  pcm_rx_shift #(.W(SLOT_BITS)) u_rx_shift (
    .clk_i, .rst_ni, .step_i(rx_step), .last_i(rx_last), .sig_i(rx_sig_live),
    .pcm_i(rx_pcm_i), .byte_o(rx_byte_o), .valid_o(rx_valid_o), .sig_o(rx_sig_o)
  );

  assign tx_pcm_oe_o      = tx_oe;
  assign tx_slot_strobe_o = tx_oe & ~var_mode_i;
  assign law_alaw_o       = alaw_sel_i;

  logic unused_ok;
  assign unused_ok = rx_start ^ rx_active;
endmodule

// File: rtl/pcm_slot_if_chk.sv
module pcm_slot_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_en_i,
  input logic var_mode_i,
  input logic tx_fs_i,
  input logic rx_fs_i,
  input logic tx_pcm_o,
  input logic tx_pcm_oe_o,
  input logic tx_slot_strobe_o,
  input logic tx_standby_o,
  input logic rx_standby_o,
  input logic rx_valid_o
);
  a_r4_strobe_fixed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_slot_strobe_o |-> (tx_pcm_oe_o && !var_mode_i));

  a_r9_pwrdn_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> (!tx_pcm_oe_o && !rx_valid_o && !tx_standby_o && !rx_standby_o));

  a_r2_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r8_tx_fs_clears_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && tx_fs_i) |=> !tx_standby_o);

  a_r8_rx_fs_clears_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && rx_fs_i) |=> !rx_standby_o);

  a_r1_oe_needs_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_pcm_oe_o) |-> $past(tx_fs_i));

  a_r12_pcm_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pcm_oe_o |-> !tx_pcm_o);
endmodule

bind pcm_slot_if pcm_slot_if_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_i(pwr_en_i), .var_mode_i(var_mode_i),
  .tx_fs_i(tx_fs_i), .rx_fs_i(rx_fs_i), .tx_pcm_o(tx_pcm_o),
  .tx_pcm_oe_o(tx_pcm_oe_o), .tx_slot_strobe_o(tx_slot_strobe_o),
  .tx_standby_o(tx_standby_o), .rx_standby_o(rx_standby_o), .rx_valid_o(rx_valid_o)
);

// File: tb/pcm_slot_if_tb_top.sv
module pcm_slot_if_tb_top;
  localparam int unsigned LIMIT = 100; // 100_000 Hz * 1 ms

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_en = 1'b0, var_mode = 1'b0, alaw = 1'b0, law;
  logic tx_fs = 1'b0, tx_dclk = 1'b0, rx_fs = 1'b0, rx_dclk = 1'b0, rx_pcm = 1'b0;
  logic [7:0] tx_byte = 8'h00, rx_byte;
  logic tx_pcm, tx_oe, tx_strobe, tx_sig, tx_stby, rx_valid, rx_sig, rx_stby;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pcm_slot_if #(.SLOT_BITS(8), .CLK_HZ(100_000), .STANDBY_MS(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .var_mode_i(var_mode),
    .alaw_sel_i(alaw), .law_alaw_o(law),
    .tx_fs_i(tx_fs), .tx_dclk_i(tx_dclk), .tx_byte_i(tx_byte), .tx_pcm_o(tx_pcm),
    .tx_pcm_oe_o(tx_oe), .tx_slot_strobe_o(tx_strobe), .tx_sig_o(tx_sig),
    .tx_standby_o(tx_stby), .rx_fs_i(rx_fs), .rx_dclk_i(rx_dclk), .rx_pcm_i(rx_pcm),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_sig_o(rx_sig), .rx_standby_o(rx_stby)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: every valid pulse must match the oldest queued expectation
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk({23'd0, rx_sig, rx_byte}, 32'h1ff, "R7 R9 unexpected rx valid");
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({23'd0, rx_sig, rx_byte}, {23'd0, e}, t);
      end
    end
  end

  task automatic fixed_frame(input bit do_tx, input bit do_rx, input bit sig,
                             input logic [7:0] b, input logic [7:0] r);
    if (do_rx) begin exp_q.push_back({sig, r}); tag_q.push_back(sig ? "R3 rx sig" : "R2"); end
    @(negedge clk);
    tx_fs = do_tx; rx_fs = do_rx; tx_byte = b;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (do_tx) begin
        chk(tx_oe, 1, "R1 oe");
        chk(tx_pcm, b[8-i], "R1 bit");
        chk(tx_strobe, 1, "R4 strobe");
        if (i >= 2) chk(tx_sig, sig, "R3 tx sig");
      end else chk(tx_oe, 0, "R10 tx idle");
      tx_fs = (i == 1) && do_tx && sig;
      rx_fs = (i == 1) && do_rx && sig;
      rx_pcm = r[8-i];
    end
    @(negedge clk);
    chk(tx_oe, 0, "R1 slot end");
    chk(tx_pcm, 0, "R12 pcm idle");
    rx_pcm = 1'b0;
  endtask

  task automatic var_frame(input logic [7:0] b, input logic [7:0] r);
    exp_q.push_back({1'b0, r}); tag_q.push_back("R6");
    @(negedge clk);
    tx_fs = 1'b1; rx_fs = 1'b1; tx_byte = b; tx_dclk = 1'b0; rx_dclk = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(tx_oe, 1, "R5 oe");
      chk(tx_pcm, b[7-k], "R5 bit");
      chk(tx_strobe, 0, "R4 no strobe");
      chk(tx_sig, 0, "R7 no sig");
      tx_dclk = 1'b1; rx_dclk = 1'b1; rx_pcm = r[7-k];
      @(negedge clk);
      chk(tx_pcm, (k < 7) ? b[6-k] : 1'b0, "R5 advance");
      tx_dclk = 1'b0; rx_dclk = 1'b0;
    end
    @(negedge clk);
    chk(tx_oe, 0, "R5 slot end");
    tx_fs = 1'b0; rx_fs = 1'b0; rx_pcm = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_oe, 0, "R12 reset oe");
    chk(tx_pcm, 0, "R12 reset pcm");
    chk(rx_valid, 0, "R12 reset valid");
    chk(tx_stby, 0, "R12 reset standby");
    rst_n = 1'b1; pwr_en = 1'b1;
    @(negedge clk);
    alaw = 1'b1; #1 chk(law, 1, "R11 alaw");
    alaw = 1'b0; #1 chk(law, 0, "R11 ulaw");

    fixed_frame(1, 1, 0, 8'hA5, 8'h3C);
    fixed_frame(1, 1, 1, 8'h81, 8'hC3);
    fixed_frame(1, 1, 0, 8'h7E, 8'h01);
    fixed_frame(0, 1, 1, 8'h00, 8'hF0);   // R10 rx alone
    fixed_frame(1, 0, 0, 8'h5A, 8'h00);   // R10 tx alone
    repeat (3) @(negedge clk);

    var_mode = 1'b1;
    var_frame(8'hC9, 8'h96);
    var_frame(8'h12, 8'hEF);

    // R7 abort after three data-clock periods
    @(negedge clk); tx_fs = 1'b1; rx_fs = 1'b1; tx_byte = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); tx_dclk = 1'b1; rx_dclk = 1'b1;
      @(negedge clk); tx_dclk = 1'b0; rx_dclk = 1'b0;
    end
    @(negedge clk); chk(tx_oe, 1, "R7 in slot");
    tx_fs = 1'b0; rx_fs = 1'b0;
    @(negedge clk); chk(tx_oe, 0, "R7 abort oe");
    repeat (12) @(negedge clk);

    // R8 standby timeout
    tx_fs = 1'b1; rx_fs = 1'b1;
    @(negedge clk); tx_fs = 1'b0; rx_fs = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    chk(tx_stby, 0, "R8 tx before limit");
    chk(rx_stby, 0, "R8 rx before limit");
    @(negedge clk);
    chk(tx_stby, 1, "R8 tx at limit");
    chk(rx_stby, 1, "R8 rx at limit");
    tx_fs = 1'b1;
    @(negedge clk);
    chk(tx_stby, 0, "R8 tx wake");
    chk(rx_stby, 1, "R8 R10 rx stays");
    tx_fs = 1'b0;
    repeat (3) @(negedge clk);

    // R9 power-down mid-slot, fixed mode
    var_mode = 1'b0;
    tx_fs = 1'b1; rx_fs = 1'b1; tx_byte = 8'hAA;
    @(negedge clk); tx_fs = 1'b0; rx_fs = 1'b0; rx_pcm = 1'b1;
    @(negedge clk); chk(tx_oe, 1, "R9 slot running");
    pwr_en = 1'b0;
    @(negedge clk);
    chk(tx_oe, 0, "R9 oe off");
    chk(tx_strobe, 0, "R9 strobe off");
    chk(rx_stby, 0, "R9 standby off");
    repeat (10) @(negedge clk);
    pwr_en = 1'b1; rx_pcm = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_oe, 0, "R9 stays idle");

    fixed_frame(1, 1, 1, 8'h0F, 8'hB7);
    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R2 R6 all results seen");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule